// File: doc/BRIEF.md
# Inter-processor message mailbox

The block is a memory-mapped peripheral through which processors pass 32-bit words to each other. It holds a parameterised number of independent message queues, each a small first-in first-out store. A producer writes a word to a queue's message register to push it. A consumer reads the same register to pop the oldest word. Per-queue status registers report whether the queue is full and how many words it currently holds.

Every queue raises two events: a word was accepted, and the queue left the full state. Both are recorded in the status register of every interrupt user. The event for queue m occupies bit 2·m (word accepted) and bit 2·m+1 (queue left full). Each user has its own enable register, and its interrupt line is asserted while any recorded event is also enabled. Software acknowledges events by writing ones to the status register.

A fixed revision word and a free configuration word complete the register set. The slave port is single-cycle. A write commits at the clock edge where it is sampled. A read's data appears on `rsp_rdata` after that same edge, and a pop caused by the read takes effect at that edge too.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty (count register reads 0, full register reads 0), every status and enable register reads 0, and every interrupt line is low.
- R2: A write to the message register at 0x040 + 4·m pushes the word into queue m. A read of it returns the oldest word of that queue on `rsp_rdata` one clock after the request and removes that word. Queues do not affect one another.
- R3: The count register at 0x0C0 + 4·m reads the number of words held (0 to DEPTH). The full register at 0x080 + 4·m reads 1 when the count equals DEPTH and 0 otherwise. A push to a full queue is discarded and leaves its contents and count unchanged.
- R4: A read of an empty queue's message register returns 0 and leaves the count at 0.
- R5: Every accepted push to queue m sets bit 2·m in the status register of every user.
- R6: A pop from a queue that was full sets bit 2·m+1 in every user's status register. A pop from a queue that was not full does not set it.
- R7: A write to the status register at 0x100 + 8·u clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: The enable register at 0x104 + 8·u stores the low 2·N_QUEUE bits written and reads them back, with the upper bits reading 0. Line `irq[u]` is high exactly when user u has a status bit that is also enabled.
- R9: Address 0x000 reads the REVISION parameter, with the major number in bits 7:4 and the minor number in bits 3:0. Address 0x010 stores a full 32-bit configuration word and reads it back unchanged.
- R10: Writes to the full, count and revision registers have no effect. Reads of addresses that map to no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A register access is requested this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, valid the cycle after a read request |
| irq | output | N_USER | One interrupt line per user |

## Verification
The checker watches, on every cycle, the following: the count bound, the discarding of pushes into a full queue, and the setting of the word-accepted and left-full bits in all users after the matching access. It also watches that an all-ones acknowledge empties a status register, that zeroing an enable drops the line, and the revision read. First-in first-out ordering across several words, the independence of queues, empty reads returning zero, the left-full bit staying clear on ordinary pops, and the ignored writes to read-only registers are shown only by the bench's scenarios. The same holds for configuration read-back and the masking of enable bits.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // register window bases, byte addresses
   localparam int unsigned REV_OFS   = 32'h000;
   localparam int unsigned CFG_OFS   = 32'h010;
   localparam int unsigned MSG_BASE  = 32'h040;
   localparam int unsigned FULL_BASE = 32'h080;
   localparam int unsigned CNT_BASE  = 32'h0C0;
   localparam int unsigned IRQ_BASE  = 32'h100;
   localparam int unsigned SPAN      = 32'h120;

   function automatic int unsigned queue_ofs(int unsigned base, int unsigned m);
      return base + 4 * m;
   endfunction

   function automatic int unsigned user_ofs(int unsigned u, bit is_enable);
      return IRQ_BASE + 8 * u + (is_enable ? 4 : 0);
   endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push_i,
   input  logic                         pop_i,
   input  logic [W-1:0]                 data_i,
   output logic [W-1:0]                 head_o,
   output logic [$clog2(DEPTH+1)-1:0]   count_o,
   output logic                         full_o,
   output logic                         push_ok_o,
   output logic                         relief_o
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_p, rd_p, wr_n, rd_n;
   logic          empty, do_pop;

   assign full_o    = (count_o == CW'(DEPTH));
   assign empty     = (count_o == '0);
   assign push_ok_o = push_i && !full_o;
   assign do_pop    = pop_i && !empty;
   assign relief_o  = do_pop && full_o;
   assign head_o    = empty ? '0 : mem[rd_p];

   // pointer wrap: free-running for power-of-two depths, compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_n = wr_p + 1'b1;
      assign rd_n = rd_p + 1'b1;
   end else begin : g_any
      assign wr_n = (wr_p == PW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
      assign rd_n = (rd_p == PW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push_ok_o) mem[wr_p] <= data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_p    <= '0;
         rd_p    <= '0;
         count_o <= '0;
      end else begin
         if (push_ok_o) wr_p <= wr_n;
         if (do_pop)    rd_p <= rd_n;
         case ({push_ok_o, do_pop})
            2'b10:   count_o <= count_o + 1'b1;
            2'b01:   count_o <= count_o - 1'b1;
            default: count_o <= count_o;
         endcase
      end
   end
endmodule

// File: rtl/mbx_irq_user.sv
module mbx_irq_user #(
   parameter int NEV = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NEV-1:0] ev_i,
   input  logic           clr_we_i,
   input  logic           en_we_i,
   input  logic [NEV-1:0] wdata_i,
   output logic [NEV-1:0] status_o,
   output logic [NEV-1:0] enable_o,
   output logic           irq_o
);
   logic [NEV-1:0] clr_mask;

   assign clr_mask = clr_we_i ? wdata_i : '0;
   assign irq_o    = |(status_o & enable_o);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_o <= '0;
         enable_o <= '0;
      end else begin
         status_o <= (status_o & ~clr_mask) | ev_i;
         if (en_we_i) enable_o <= wdata_i;
      end
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import mbx_pkg::*;
#(
   parameter int         DATA_W   = 32,
   parameter int         ADDR_W   = 9,
   parameter int         N_QUEUE  = 4,
   parameter int         N_USER   = 4,
   parameter int         DEPTH    = 4,
   parameter logic [7:0] REVISION = 8'h21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [N_USER-1:0] irq
);
   localparam int NEV = 2 * N_QUEUE;
   localparam int CW  = $clog2(DEPTH + 1);

   // elaboration-time parameter checks
   if (N_QUEUE < 1 || 4 * N_QUEUE > FULL_BASE - MSG_BASE) begin : g_bad_queue
      $error("N_QUEUE does not fit its register window");
   end
   if (N_USER < 1 || 8 * N_USER > SPAN - IRQ_BASE) begin : g_bad_user
      $error("N_USER does not fit the interrupt window");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (NEV > DATA_W || DATA_W < 8) begin : g_bad_width
      $error("DATA_W too narrow for event bits or revision");
   end
   if ((1 << ADDR_W) < SPAN) begin : g_bad_addr
      $error("ADDR_W too narrow for the register space");
   end

   logic [N_QUEUE-1:0]    hit_msg, hit_full, hit_cnt;
   logic [N_QUEUE-1:0]    full, push_ok, relief;
   logic [DATA_W-1:0]     head [N_QUEUE];
   logic [N_QUEUE*CW-1:0] q_count_flat;
   logic [NEV-1:0]        ev;
   logic [N_USER-1:0]     hit_st, hit_en;
   logic [N_USER*NEV-1:0] st_flat, en_flat;
   logic                  hit_rev, hit_cfg;
   logic [DATA_W-1:0]     cfg_q, rd_mux;

   assign hit_rev = req_valid && (req_addr == ADDR_W'(REV_OFS));
   assign hit_cfg = req_valid && (req_addr == ADDR_W'(CFG_OFS));

   for (genvar m = 0; m < N_QUEUE; m++) begin : g_queue
      assign hit_msg[m]  = req_valid && (req_addr == ADDR_W'(queue_ofs(MSG_BASE, m)));
      assign hit_full[m] = req_valid && (req_addr == ADDR_W'(queue_ofs(FULL_BASE, m)));
      assign hit_cnt[m]  = req_valid && (req_addr == ADDR_W'(queue_ofs(CNT_BASE, m)));
      assign ev[2*m]     = push_ok[m];
      assign ev[2*m+1]   = relief[m];

      mbx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_q (
         .clk       (clk),
         .rst_n     (rst_n),
         .push_i    (hit_msg[m] && req_write),
         .pop_i     (hit_msg[m] && !req_write),
         .data_i    (req_wdata),
         .head_o    (head[m]),
         .count_o   (q_count_flat[m*CW +: CW]),
         .full_o    (full[m]),
         .push_ok_o (push_ok[m]),
         .relief_o  (relief[m])
      );
   end

   for (genvar u = 0; u < N_USER; u++) begin : g_user
      assign hit_st[u] = req_valid && (req_addr == ADDR_W'(user_ofs(u, 1'b0)));
      assign hit_en[u] = req_valid && (req_addr == ADDR_W'(user_ofs(u, 1'b1)));

      mbx_irq_user #(.NEV(NEV)) u_usr (
         .clk      (clk),
         .rst_n    (rst_n),
         .ev_i     (ev),
         .clr_we_i (hit_st[u] && req_write),
         .en_we_i  (hit_en[u] && req_write),
         .wdata_i  (req_wdata[NEV-1:0]),
         .status_o (st_flat[u*NEV +: NEV]),
         .enable_o (en_flat[u*NEV +: NEV]),
         .irq_o    (irq[u])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     cfg_q <= '0;
      else if (hit_cfg && req_write)  cfg_q <= req_wdata;
   end

   always_comb begin
      rd_mux = '0;
      if (hit_rev) rd_mux = DATA_W'(REVISION);
      if (hit_cfg) rd_mux = cfg_q;
      for (int m = 0; m < N_QUEUE; m++) begin
         if (hit_msg[m])  rd_mux = head[m];
         if (hit_full[m]) rd_mux = DATA_W'(full[m]);
         if (hit_cnt[m])  rd_mux = DATA_W'(q_count_flat[m*CW +: CW]);
      end
      for (int u = 0; u < N_USER; u++) begin
         if (hit_st[u]) rd_mux = DATA_W'(st_flat[u*NEV +: NEV]);
         if (hit_en[u]) rd_mux = DATA_W'(en_flat[u*NEV +: NEV]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       rsp_rdata <= '0;
      else if (req_valid && !req_write) rsp_rdata <= rd_mux;
   end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
   import mbx_pkg::*;
#(
   parameter int         DATA_W   = 32,
   parameter int         ADDR_W   = 9,
   parameter int         N_QUEUE  = 4,
   parameter int         N_USER   = 4,
   parameter int         DEPTH    = 4,
   parameter logic [7:0] REVISION = 8'h21,
   parameter int         NEV      = 2 * N_QUEUE,
   parameter int         CW       = $clog2(DEPTH + 1)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_write,
   input logic [ADDR_W-1:0]     req_addr,
   input logic [DATA_W-1:0]     req_wdata,
   input logic [DATA_W-1:0]     rsp_rdata,
   input logic [N_USER-1:0]     irq,
   input logic [N_QUEUE*CW-1:0] q_count_flat,
   input logic [N_USER*NEV-1:0] st_flat
);
   assert_rev_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == ADDR_W'(REV_OFS))
      |=> rsp_rdata == DATA_W'(REVISION));

   for (genvar m = 0; m < N_QUEUE; m++) begin : g_q
      logic msg_hit;
      assign msg_hit = req_valid && (req_addr == ADDR_W'(queue_ofs(MSG_BASE, m)));

      assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
         q_count_flat[m*CW +: CW] <= CW'(DEPTH));

      assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (msg_hit && req_write && q_count_flat[m*CW +: CW] == CW'(DEPTH))
         |=> q_count_flat[m*CW +: CW] == CW'(DEPTH));

      for (genvar u = 0; u < N_USER; u++) begin : g_u
         assert_newmsg_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (msg_hit && req_write && q_count_flat[m*CW +: CW] < CW'(DEPTH))
            |=> st_flat[u*NEV + 2*m]);

         assert_relief_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (msg_hit && !req_write && q_count_flat[m*CW +: CW] == CW'(DEPTH))
            |=> st_flat[u*NEV + 2*m + 1]);
      end
   end

   for (genvar u = 0; u < N_USER; u++) begin : g_usr
      assert_ack_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_write && req_addr == ADDR_W'(user_ofs(u, 1'b0))
          && (&req_wdata[NEV-1:0]))
         |=> st_flat[u*NEV +: NEV] == '0);

      assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_write && req_addr == ADDR_W'(user_ofs(u, 1'b1))
          && req_wdata[NEV-1:0] == '0)
         |=> !irq[u]);
   end
endmodule

bind ipc_mailbox mbx_checker #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .N_QUEUE  (N_QUEUE),
   .N_USER   (N_USER),
   .DEPTH    (DEPTH),
   .REVISION (REVISION)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_write    (req_write),
   .req_addr     (req_addr),
   .req_wdata    (req_wdata),
   .rsp_rdata    (rsp_rdata),
   .irq          (irq),
   .q_count_flat (q_count_flat),
   .st_flat      (st_flat)
);

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [8:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic [3:0]  irq;

   int vecs = 0;
   int miss = 0;
   logic chk_due = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   ipc_mailbox u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq(irq)
   );

   function automatic logic [8:0] a_msg(int m);  return 9'(32'h040 + 4*m); endfunction
   function automatic logic [8:0] a_full(int m); return 9'(32'h080 + 4*m); endfunction
   function automatic logic [8:0] a_cnt(int m);  return 9'(32'h0C0 + 4*m); endfunction
   function automatic logic [8:0] a_st(int u);   return 9'(32'h100 + 8*u); endfunction
   function automatic logic [8:0] a_en(int u);   return 9'(32'h104 + 8*u); endfunction

   // driver: issue a read and queue the expected response
   task automatic rd(input logic [8:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic chk_irq(input logic [3:0] e, input string t);
      vecs++;
      if (irq !== e) begin
         miss++;
         $display("FAIL %s: irq got %b expected %b", t, irq, e);
      end
   endtask

   // monitor: one response per read, compared one clock after the request
   always @(posedge clk) chk_due <= rst_n && req_valid && !req_write;

   always @(negedge clk) begin
      if (chk_due) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         vecs++;
         if (rsp_rdata !== e) begin
            miss++;
            $display("FAIL %s: rdata got %h expected %h", t, rsp_rdata, e);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      miss++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_irq(4'b0000, "R1 irq after reset");
      for (int m = 0; m < 4; m++) begin
         rd(a_cnt(m), 0, "R1 count after reset");
         rd(a_full(m), 0, "R1 full after reset");
      end
      for (int u = 0; u < 4; u++) begin
         rd(a_st(u), 0, "R1 status after reset");
         rd(a_en(u), 0, "R1 enable after reset");
      end

      // revision and configuration
      rd(9'h000, 32'h21, "R9 revision");
      wr(9'h010, 32'hA5C3_0F11);
      rd(9'h010, 32'hA5C3_0F11, "R9 config readback");

      // queue 0: two words, event in all users, no irq while disabled
      wr(a_msg(0), 32'hAAAA_0001);
      wr(a_msg(0), 32'hBBBB_0002);
      rd(a_cnt(0), 2, "R3 count two");
      rd(a_st(0), 32'h1, "R5 newmsg user0");
      rd(a_st(2), 32'h1, "R5 newmsg user2");
      idle();
      chk_irq(4'b0000, "R8 irq masked");
      wr(a_en(1), 32'h1);
      rd(a_en(1), 32'h1, "R8 enable readback");
      idle();
      chk_irq(4'b0010, "R8 irq user1");

      // acknowledge
      wr(a_st(1), 32'h0);
      rd(a_st(1), 32'h1, "R7 zero write keeps bit");
      wr(a_st(1), 32'h1);
      rd(a_st(1), 32'h0, "R7 one write clears bit");
      idle();
      chk_irq(4'b0000, "R8 irq drops after ack");

      // pops in order, then empty
      rd(a_msg(0), 32'hAAAA_0001, "R2 first pop");
      rd(a_msg(0), 32'hBBBB_0002, "R2 second pop");
      rd(a_cnt(0), 0, "R2 count after pops");
      rd(a_msg(0), 0, "R4 empty read");
      rd(a_cnt(0), 0, "R4 count stays zero");

      // queue 1: fill, overflow, left-full event
      wr(a_st(0), 32'hFF);
      for (int i = 0; i < 4; i++) wr(a_msg(1), 32'hC000_0000 + i);
      wr(a_msg(1), 32'hDEAD_BEEF);
      rd(a_full(1), 1, "R3 full flag");
      rd(a_cnt(1), 4, "R3 count at depth");
      rd(a_st(0), 32'h04, "R6 no relief before pop");
      wr(a_en(0), 32'h08);
      idle();
      chk_irq(4'b0000, "R8 relief not yet");
      rd(a_msg(1), 32'hC000_0000, "R2 pop from full");
      rd(a_st(0), 32'h0C, "R6 relief bit set");
      idle();
      chk_irq(4'b0001, "R8 irq on relief");
      rd(a_full(1), 0, "R3 full flag clears");
      wr(a_st(0), 32'hFF);
      rd(a_msg(1), 32'hC000_0001, "R2 pop 2");
      rd(a_msg(1), 32'hC000_0002, "R2 pop 3");
      rd(a_msg(1), 32'hC000_0003, "R3 last kept word");
      rd(a_st(0), 32'h0, "R6 no relief when not full");
      rd(a_cnt(1), 0, "R3 overflow word dropped");
      rd(a_msg(1), 0, "R3 dropped word absent");

      // ignored writes and unmapped reads
      wr(a_full(2), 32'hFFFF_FFFF);
      wr(a_cnt(2), 32'h5);
      wr(9'h000, 32'h0);
      rd(a_cnt(2), 0, "R10 count write ignored");
      rd(a_full(2), 0, "R10 full write ignored");
      rd(9'h000, 32'h21, "R10 revision write ignored");
      wr(9'h030, 32'h1234_5678);
      rd(9'h030, 0, "R10 unmapped read");

      // independence of queues
      wr(a_msg(3), 32'hEEEE_0003);
      wr(a_msg(2), 32'hFFFF_0002);
      rd(a_msg(3), 32'hEEEE_0003, "R2 queue3 word");
      rd(a_msg(2), 32'hFFFF_0002, "R2 queue2 word");

      // enable width masking
      wr(a_en(2), 32'hFFFF_FFFF);
      rd(a_en(2), 32'h0000_00FF, "R8 enable masked");
      idle();
      idle();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end
endmodule